// File: doc/BRIEF.md
# I2C Target Address Front End

This block is the receiving side of an I2C target at the point where a transfer begins. It brings the bus clock and data lines into the local clock domain, finds START and STOP conditions, shifts in the address phase and compares it with a programmed own address. It supports both 7-bit and 10-bit addressing. On a match it pulls SDA low during the acknowledge clock, and it reports that it has been selected together with the direction bit. Data transfer after the address phase is left to the logic that follows.

A small write-only register port sets up the block. Register 0 is a global enable. Register 1 holds a 10-bit own address. Register 2 holds control bits that choose the address width and gate target operation. The address and control registers are locked while the block is enabled. The two-stage line synchronizers reset to the idle-high level. After reset, bus-condition detection stays muted for a settle interval, so a reset released in the middle of a transfer cannot produce a false START.

Top module: `i2c_tgt_front`

## Requirements
- R1: Register writes use `reg_sel`. Select 0 writes the enable (bit 0). Select 1 writes the own address (bits 9:0), which resets to 0x055. Select 2 writes the control word: bit 0 is master mode, bit 3 is 10-bit addressing (1 = 10-bit), and bit 6 is target disable. The control word resets with bits 0 and 6 set and bit 3 clear.
- R2: While the enable bit is 1, writes to the own-address and control registers are ignored. Enable writes are always accepted.
- R3: The block acts on the bus only when enable = 1, control bit 6 = 0 and control bit 0 = 0. Otherwise it never pulls SDA and never reports selection.
- R4: The line synchronizers reset to 1. No START or STOP is detected during the first SETTLE_CYC (default 6) clock cycles after reset is released.
- R5: A START is synchronized SDA falling while synchronized SCL is high. A STOP is synchronized SDA rising while synchronized SCL is high.
- R6: In 7-bit mode, the first byte after START is bits sent MSB first. If its bits 7:1 equal address bits 6:0, the block pulls SDA low for the whole ninth SCL pulse. It then raises `selected` and reports bit 0 of that byte on `rd_wr`.
- R7: In 7-bit mode, a first byte whose bits 7:3 are 11110 is never acknowledged, even if bits 7:1 equal the address.
- R8: In 10-bit mode, the first byte is acknowledged only if bits 7:3 are 11110, bits 2:1 equal address bits 9:8, and bit 0 is 0.
- R9: In 10-bit mode, after an acknowledged header, the second byte is acknowledged only if it equals address bits 7:0. `selected` rises only after both bytes match, and `rd_wr` then reads 0.
- R10: A byte that does not match leaves SDA released. The block then ignores all bus traffic until the next START.
- R11: A START in any state, including a repeated START or one in the middle of a byte, restarts address reception. A STOP clears `selected` and returns the block to idle.
- R12: Out of reset, `sda_pull`, `selected` and `rd_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 enable, 1 own address, 2 control) |
| reg_wdata | input | 10 | Register write data |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| selected | output | 1 | Address phase matched; held until STOP or START |
| rd_wr | output | 1 | Direction bit of the matched 7-bit address |

## Verification
The most delicate overlap is a START that arrives while the address engine is busy elsewhere. Examples are a START during the acknowledge clock, directly after the ninth pulse, or in the middle of a byte. In each case the restart must win over the pending shift or acknowledge release. The bench provokes these cases with repeated STARTs and with STARTs cut into a half-sent byte. It judges them by whether the next full address is acknowledged exactly as the bench's own match functions predict. A second overlap is the reset-time fall of the synchronizer output landing in the same cycles as the first enabling register writes. This is provoked by releasing reset while SDA is held low under a high SCL. It is judged by the absence of an acknowledge for a matching byte that is sent with no real START.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int ADDR_W = 10;
  localparam int CTRL_W = 7;
  localparam int CTRL_MASTER_BIT = 0;
  localparam int CTRL_TEN_BIT    = 3;
  localparam int CTRL_SLVDIS_BIT = 6;
  localparam logic [4:0] HDR10_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX1, ST_ACK1, ST_RX2, ST_ACK2, ST_SEL
  } tgt_state_e;

  // R6/R7: 7-bit compare, reserved 10-bit header never matches
  function automatic logic match_short(input logic [7:0] b, input logic [ADDR_W-1:0] a);
    return (b[7:1] == a[6:0]) && (b[7:3] != HDR10_TAG);
  endfunction

  // R8: 10-bit header byte compare (write direction only)
  function automatic logic match_long_hdr(input logic [7:0] b, input logic [ADDR_W-1:0] a);
    return (b[7:3] == HDR10_TAG) && (b[2:1] == a[9:8]) && !b[0];
  endfunction

  // R9: 10-bit low byte compare
  function automatic logic match_long_low(input logic [7:0] b, input logic [ADDR_W-1:0] a);
    return b == a[7:0];
  endfunction
endpackage

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_RST = 10'h055,
  parameter logic [CTRL_W-1:0] CTRL_RST = 7'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic              en_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic cfg_open;
  assign cfg_open = !en_q;  // R2

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= ADDR_RST;
      ctrl_q <= CTRL_RST;
    end else if (wr) begin
      case (sel)
        2'd0: en_q <= wdata[0];
        2'd1: if (cfg_open) addr_q <= wdata;
        2'd2: if (cfg_open) ctrl_q <= wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic settled,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [1:0] line_in, line_s, line_q;
  logic [CNT_W-1:0] settle_cnt;
  logic scl_s;

  assign line_in = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe      <= '1;  // R4: idle-high reset
        line_q[g] <= 1'b1;
      end else begin
        pipe      <= {pipe[SYNC_STAGES-2:0], line_in[g]};
        line_q[g] <= pipe[SYNC_STAGES-1];
      end
    end
    assign line_s[g] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_cnt <= '0;
    else if (!settled) settle_cnt <= settle_cnt + 1'b1;
  end
  assign settled = (settle_cnt == CNT_W'(SETTLE_CYC));

  assign scl_s     = line_s[0];
  assign sda_s     = line_s[1];
  assign start_evt = settled && scl_s && line_q[0] && line_q[1] && !sda_s;  // R5
  assign stop_evt  = settled && scl_s && line_q[0] && !line_q[1] && sda_s;  // R5
  assign scl_rise  = scl_s && !line_q[0];
  assign scl_fall  = !scl_s && line_q[0];
endmodule

// File: rtl/i2ct_addr_fsm.sv
module i2ct_addr_fsm
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              mode10,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  output logic              sda_pull,
  output logic              selected,
  output logic              rd_wr
);
  tgt_state_e state;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic byte_done, hit1, hit2;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign hit1 = mode10 ? match_long_hdr(shreg, own_addr) : match_short(shreg, own_addr);
  assign hit2 = match_long_low(shreg, own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; shreg <= '0; bitcnt <= '0;
      sda_pull <= 1'b0; selected <= 1'b0; rd_wr <= 1'b0;
    end else if (!active) begin            // R3
      state <= ST_IDLE; sda_pull <= 1'b0; selected <= 1'b0;
    end else if (start_evt) begin          // R11
      state <= ST_RX1; bitcnt <= '0; sda_pull <= 1'b0; selected <= 1'b0;
    end else if (stop_evt) begin           // R11
      state <= ST_IDLE; sda_pull <= 1'b0; selected <= 1'b0;
    end else begin
      case (state)
        ST_RX1, ST_RX2: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if ((state == ST_RX1) ? hit1 : hit2) begin
              sda_pull <= 1'b1;
              state    <= (state == ST_RX1) ? ST_ACK1 : ST_ACK2;
              if (state == ST_RX1) rd_wr <= mode10 ? 1'b0 : shreg[0];
            end else begin
              state <= ST_IDLE;            // R10
            end
          end
        end
        ST_ACK1: if (scl_fall) begin
          sda_pull <= 1'b0;
          bitcnt   <= '0;
          state    <= mode10 ? ST_RX2 : ST_SEL;
          selected <= !mode10;
        end
        ST_ACK2: if (scl_fall) begin
          sda_pull <= 1'b0; state <= ST_SEL; selected <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_front.sv
module i2c_tgt_front
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic              selected,
  output logic              rd_wr
);
  logic              en_q;
  logic [ADDR_W-1:0] own_addr;
  logic [CTRL_W-1:0] ctrl_q;
  logic sda_s, settled, start_evt, stop_evt, scl_rise, scl_fall, active;

  i2ct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .en_q(en_q), .addr_q(own_addr), .ctrl_q(ctrl_q)
  );

  i2ct_sync #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_CYC(SETTLE_CYC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .settled(settled), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  assign active = en_q && !ctrl_q[CTRL_SLVDIS_BIT] && !ctrl_q[CTRL_MASTER_BIT];

  i2ct_addr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .active(active), .mode10(ctrl_q[CTRL_TEN_BIT]),
    .own_addr(own_addr), .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_pull(sda_pull), .selected(selected), .rd_wr(rd_wr)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic [ADDR_W-1:0] own_addr,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              active,
  input logic              settled,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              scl_fall,
  input logic              sda_pull,
  input logic              selected
);
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> ($stable(own_addr) && $stable(ctrl_q))); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull || selected) |-> $past(active)); // R3
  AST_NO_EVT_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> (!start_evt && !stop_evt)); // R4
  AST_ACK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall)); // R6
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_pull && !selected)); // R11
  AST_STOP_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> !selected); // R11
  AST_SEL_NOT_ACKING: assert property (@(posedge clk) disable iff (!rst_n)
    !(selected && sda_pull)); // R9
endmodule

bind i2c_tgt_front i2ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .own_addr(own_addr), .ctrl_q(ctrl_q),
  .active(active), .settled(settled), .start_evt(start_evt), .stop_evt(stop_evt),
  .scl_fall(scl_fall), .sda_pull(sda_pull), .selected(selected)
);

// File: tb/i2c_tgt_front_tb.sv
module i2c_tgt_front_tb;
  localparam int Q = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [9:0] reg_wdata = '0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, selected, rd_wr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_tgt_front u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .scl_in(scl_m), .sda_in(sda_m & ~sda_pull),
    .sda_pull(sda_pull), .selected(selected), .rd_wr(rd_wr)
  );

  // bench-side address rules
  function automatic bit want_short(input logic [7:0] b, input logic [9:0] a);
    bit tenhdr = (b[7:4] == 4'hF) && (b[3] == 1'b0);
    return !tenhdr && (b[7:1] == a[6:0]);
  endfunction
  function automatic bit want_hdr(input logic [7:0] b, input logic [9:0] a);
    return b == {5'b11110, a[9:8], 1'b0};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask
  task automatic wreg(input logic [1:0] s, input logic [9:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask
  task automatic setup(input logic [9:0] a, input bit ten);
    wreg(2'd0, 10'd0); wreg(2'd1, a); wreg(2'd2, ten ? 10'h008 : 10'h000); wreg(2'd0, 10'd1);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait(); scl_m = 1'b1; qwait(); scl_m = 1'b0;
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); qwait();
    ack = sda_pull;
    scl_m = 1'b0; qwait();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic ack, ack2;
    int seed_v = $urandom(32'h1C2A);
    // R4: reset released mid-transfer (SCL high, SDA low), enable at once
    scl_m = 1'b1; sda_m = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 sda_pull reset", sda_pull, 1'b0);
    chk("R12 selected reset", selected, 1'b0);
    chk("R12 rd_wr reset", rd_wr, 1'b0);
    rst_n = 1'b1;
    wreg(2'd2, 10'h000); wreg(2'd0, 10'd1);
    scl_m = 1'b0; qwait();
    send_byte(8'hAA, ack);
    chk("R4 no false START after reset", ack, 1'b0);
    chk("R4 not selected", selected, 1'b0);
    bus_stop();

    // R1: default address 0x055 in 7-bit mode, read direction
    bus_start(); send_byte(8'hAB, ack);
    chk("R1 default address acked", ack, 1'b1);
    chk("R6 selected after ack", selected, 1'b1);
    chk("R6 rd_wr", rd_wr, 1'b1);
    bus_stop();
    chk("R5 STOP clears selected", selected, 1'b0);

    // R3: control defaults block operation
    wreg(2'd0, 10'd0); wreg(2'd2, 10'h041); wreg(2'd0, 10'd1);
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk("R3 both gate bits set", ack, 1'b0);
    wreg(2'd0, 10'd0); wreg(2'd2, 10'h001); wreg(2'd0, 10'd1);
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk("R3 master bit set", ack, 1'b0);
    wreg(2'd0, 10'd0); wreg(2'd2, 10'h040); wreg(2'd0, 10'd1);
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk("R3 target disable set", ack, 1'b0);
    wreg(2'd0, 10'd0);
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    chk("R3 enable clear", ack, 1'b0);

    // R2: writes while enabled ignored
    setup(10'h023, 1'b0);
    wreg(2'd1, 10'h011); wreg(2'd2, 10'h008);
    bus_start(); send_byte(8'h46, ack); bus_stop();
    chk("R2 old address still acked", ack, 1'b1);
    bus_start(); send_byte(8'h22, ack); bus_stop();
    chk("R2 new address not taken", ack, 1'b0);

    // R7: 7-bit target whose address looks like a 10-bit header
    setup(10'h078, 1'b0);
    bus_start(); send_byte(8'hF0, ack); bus_stop();
    chk("R7 header ignored in 7-bit mode", ack, 1'b0);

    // R10: mismatch then matching byte without START
    setup(10'h023, 1'b0);
    bus_start(); send_byte(8'h10, ack);
    chk("R10 mismatch nack", ack, 1'b0);
    send_byte(8'h46, ack);
    chk("R10 ignored until START", ack, 1'b0);
    bus_stop();

    // R11: START cut into a byte, and repeated START after an ack
    bus_start(); send_bits(8'h46, 4);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    send_byte(8'h46, ack);
    chk("R11 START mid-byte restarts", ack, 1'b1);
    bus_start();
    chk("R11 repeated START deselects", selected, 1'b0);
    send_byte(8'h47, ack);
    chk("R11 repeated START address", ack, 1'b1);
    chk("R6 rd_wr after repeat", rd_wr, 1'b1);
    bus_stop();

    // R8/R9: 10-bit directed
    setup(10'h2C5, 1'b1);
    bus_start(); send_byte(8'hF4, ack); send_byte(8'hC5, ack2);
    chk("R8 header ack", ack, 1'b1);
    chk("R9 low byte ack", ack2, 1'b1);
    chk("R9 selected", selected, 1'b1);
    chk("R9 rd_wr zero", rd_wr, 1'b0);
    bus_stop();
    bus_start(); send_byte(8'hF5, ack); bus_stop();
    chk("R8 read header nack", ack, 1'b0);
    bus_start(); send_byte(8'h62, ack); bus_stop();
    chk("R8 7-bit byte in 10-bit mode", ack, 1'b0);
    bus_start(); send_byte(8'hF4, ack); send_byte(8'hC4, ack2);
    chk("R9 low byte mismatch", ack2, 1'b0);
    chk("R9 not selected", selected, 1'b0);
    bus_stop();

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [9:0] a; bit ten; logic [7:0] b1, b2;
      a = 10'($urandom); ten = 1'($urandom);
      setup(a, ten);
      if ($urandom % 2) b1 = ten ? {5'b11110, a[9:8], 1'b0} : {a[6:0], 1'($urandom)};
      else b1 = 8'($urandom);
      bus_start(); send_byte(b1, ack);
      if (!ten) begin
        chk("R6 random 7-bit ack", ack, logic'(want_short(b1, a)));
        chk("R6 random 7-bit sel", selected, logic'(want_short(b1, a)));
        if (want_short(b1, a)) chk("R6 random rd_wr", rd_wr, b1[0]);
      end else begin
        chk("R8 random header ack", ack, logic'(want_hdr(b1, a)));
        if (ack) begin
          b2 = ($urandom % 2) ? a[7:0] : 8'($urandom);
          send_byte(b2, ack2);
          chk("R9 random low ack", ack2, logic'(b2 == a[7:0]));
          chk("R9 random sel", selected, logic'(b2 == a[7:0]));
        end
      end
      bus_stop();
      chk("R11 random STOP", selected, 1'b0);
    end

    if (seed_v == -1) $display("seed");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1;
    $finish;
  end
endmodule